// File: doc/BRIEF.md
# UART FIFO Threshold Interrupt Controller

This block turns the fill levels of a serial port's transmit and receive queues, the receiver's error and timeout events, modem-line change events and an error-data condition into a set of twelve sticky interrupt status bits. Each status bit is then gated by a programmable mask and folded into a single interrupt line. The same logic that decides whether the receive queue has reached its trigger level also drives a hardware request-to-send output, so a remote sender is throttled once the local receive queue fills.

Software programs two 3-bit trigger codes, the mask and two control bits through plain write strobes with data. It acknowledges interrupts by writing ones to a clear port. Both queues are DEPTH entries deep (64 by default). Each queue reports its current occupancy from 0 to DEPTH. The queue storage, the serial shifters and the bus decoder sit outside this block.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset the raw status is 0x020 (only the transmit bit, position 5, set), the mask is 0xFFF, the masked status and the interrupt are 0, both trigger codes are 3'b010, and hardware RTS is disabled, so rts_active is 0.
- R2: Receive trigger codes 0, 1, 2, 3 and 4 are met when rx_level is at least 1/8, 1/4, 1/2, 3/4 and 7/8 of DEPTH respectively. While the code is met, raw bit 4 is set at the next clock edge.
- R3: Receive code 5 is met when rx_level >= 1 and code 6 when rx_level >= 2. Code 7 is reserved and never sets raw bit 4.
- R4: Transmit trigger codes 0 to 4 are met when tx_level is below 1/8, 1/4, 1/2, 3/4 and 7/8 of DEPTH respectively, and then set raw bit 5 at the next edge. Codes 5 to 7 are reserved and never set it.
- R5: A one-cycle event sets its raw bit at the next edge: overrun bit 10, break bit 9, parity bit 8, framing bit 7, receive timeout bit 6, and modem_chg[3:0] into bits 3 (DSR), 2 (DCD), 1 (CTS) and 0 (RI). A set bit holds until it is cleared.
- R6: A clear write with a 1 in bit k clears raw bit k at the next edge. A 0 has no effect. If a set condition for bit k is present in the same cycle, the set wins.
- R7: masked_stat equals raw_stat AND NOT mask, where a mask bit of 1 blocks its source. irq is the OR of all bits of masked_stat.
- R8: With hardware RTS enabled, rts_active is 1 exactly while the receive trigger code is not met, and a reserved receive code counts as never met. With it disabled, rts_active is 0.
- R9: While err_data_pending is 1, raw bit 11 is set at each edge. Raw bit 4 is set only if the ignore-error-data control bit is 1 or err_data_pending is 0.
- R10: Writes to the trigger codes, the mask and the control bits take effect from the edge on which they are written. Status evaluation in that same edge still uses the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_we | input | 1 | Write strobe for both trigger codes |
| trig_rx_sel | input | 3 | Receive trigger code to write |
| trig_tx_sel | input | 3 | Transmit trigger code to write |
| mask_we | input | 1 | Write strobe for the mask |
| mask_wdata | input | 12 | Mask value (1 blocks) |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_rts_hw | input | 1 | Hardware RTS enable to write |
| ctl_ign_err | input | 1 | Ignore-error-data bit to write |
| clr_we | input | 1 | Clear-port write strobe |
| clr_wdata | input | 12 | Write-1-to-clear data |
| rx_level | input | $clog2(DEPTH+1) (7) | Receive queue occupancy |
| tx_level | input | $clog2(DEPTH+1) (7) | Transmit queue occupancy |
| ev_overrun | input | 1 | Receive overrun event |
| ev_break | input | 1 | Break event |
| ev_parity | input | 1 | Parity error event |
| ev_framing | input | 1 | Framing error event |
| ev_rx_timeout | input | 1 | Receive timeout event |
| modem_chg | input | 4 | Modem change events: DSR, DCD, CTS, RI |
| err_data_pending | input | 1 | Receive queue holds flagged data |
| raw_stat | output | 12 | Raw status |
| masked_stat | output | 12 | Status after masking |
| irq | output | 1 | Combined interrupt |
| rts_active | output | 1 | Hardware request-to-send, active high |

## Verification
The assertions assume that rx_level and tx_level never exceed DEPTH. They also assume that the event inputs are synchronous to clk and remain stable across each edge. The bench drives every input on the falling edge and keeps both levels within 0 to DEPTH, including the end points in each sweep. Every trigger code, including the reserved ones, is swept through all levels. A clear of all ones is written on each cycle of a sweep, so the raw bit reflects only that cycle's condition. Event, clear and mask patterns come from a pseudo-random generator, while error data is toggled in directed steps.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   localparam int NSTAT = 12;

   localparam int ST_ERRDATA = 11;
   localparam int ST_OVERRUN = 10;
   localparam int ST_BREAK   = 9;
   localparam int ST_PARITY  = 8;
   localparam int ST_FRAMING = 7;
   localparam int ST_RXTMO   = 6;
   localparam int ST_TXLVL   = 5;
   localparam int ST_RXLVL   = 4;
   localparam int ST_DSR     = 3;
   localparam int ST_DCD     = 2;
   localparam int ST_CTS     = 1;
   localparam int ST_RI      = 0;

   localparam logic [NSTAT-1:0] RAW_RESET  = NSTAT'(1) << ST_TXLVL;
   localparam logic [NSTAT-1:0] MASK_RESET = '1;
   localparam logic [2:0]       SEL_RESET  = 3'b010;

   typedef struct packed {
      logic [2:0] rx_sel;
      logic [2:0] tx_sel;
      logic       rts_hw;
      logic       ign_err;
   } cfg_t;

   // Fraction of the queue depth, in eighths, for the shared codes 0..4.
   function automatic int unsigned frac_eighths(input logic [2:0] code);
      case (code)
         3'd0:    frac_eighths = 1;
         3'd1:    frac_eighths = 2;
         3'd2:    frac_eighths = 4;
         3'd3:    frac_eighths = 6;
         3'd4:    frac_eighths = 7;
         default: frac_eighths = 0;
      endcase
   endfunction

endpackage

// File: rtl/uirq_cfg_regs.sv
module uirq_cfg_regs
   import uirq_pkg::*;
#(
   parameter int NST = NSTAT
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           trig_we,
   input  logic [2:0]     trig_rx_sel,
   input  logic [2:0]     trig_tx_sel,
   input  logic           ctl_we,
   input  logic           ctl_rts_hw,
   input  logic           ctl_ign_err,
   input  logic           mask_we,
   input  logic [NST-1:0] mask_wdata,
   output cfg_t           cfg,
   output logic [NST-1:0] mask
);

   cfg_t           cfg_q;
   logic [NST-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.rx_sel <= SEL_RESET;
         cfg_q.tx_sel <= SEL_RESET;
      end else if (trig_we) begin
         cfg_q.rx_sel <= trig_rx_sel;
         cfg_q.tx_sel <= trig_tx_sel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.rts_hw  <= 1'b0;
         cfg_q.ign_err <= 1'b0;
      end else if (ctl_we) begin
         cfg_q.rts_hw  <= ctl_rts_hw;
         cfg_q.ign_err <= ctl_ign_err;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= NST'(MASK_RESET);
      else if (mask_we) mask_q <= mask_wdata;
   end

   assign cfg  = cfg_q;
   assign mask = mask_q;

endmodule

// File: rtl/uirq_level_cmp.sv
module uirq_level_cmp #(
   parameter int  DEPTH = 64,
   parameter bit  IS_RX = 1'b1,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic [2:0]       code,
   input  logic [LVL_W-1:0] level,
   output logic             hit
);

   logic [LVL_W-1:0] frac_thr;

   always_comb begin
      frac_thr = LVL_W'((DEPTH * uirq_pkg::frac_eighths(code)) / 8);
   end

   generate
      if (IS_RX) begin : g_rx
         // Fill threshold: fractional codes, two absolute codes, one reserved.
         always_comb begin
            case (code)
               3'd5:    hit = (level >= LVL_W'(1));
               3'd6:    hit = (level >= LVL_W'(2));
               3'd7:    hit = 1'b0;
               default: hit = (level >= frac_thr);
            endcase
         end
      end else begin : g_tx
         // Drain threshold: fractional codes only, upper three reserved.
         logic code_ok;
         always_comb begin
            code_ok = (code <= 3'd4);
            hit     = code_ok && (level < frac_thr);
         end
      end
   endgenerate

endmodule

// File: rtl/uirq_status_bank.sv
module uirq_status_bank #(
   parameter int              NST     = 12,
   parameter logic [NST-1:0]  RAW_RST = '0,
   parameter bit              REG_IRQ = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NST-1:0] set_vec,
   input  logic           clr_we,
   input  logic [NST-1:0] clr_wdata,
   input  logic [NST-1:0] mask,
   output logic [NST-1:0] raw_stat,
   output logic [NST-1:0] masked_stat,
   output logic           irq
);

   logic [NST-1:0] raw_q;
   logic [NST-1:0] clr_vec;
   logic [NST-1:0] raw_d;

   always_comb begin
      clr_vec = clr_we ? clr_wdata : '0;
      // A condition present in the clearing cycle re-asserts its bit.
      raw_d   = (raw_q & ~clr_vec) | set_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= RAW_RST;
      else        raw_q <= raw_d;
   end

   always_comb begin
      masked_stat = raw_q & ~mask;
   end

   assign raw_stat = raw_q;

   generate
      if (REG_IRQ) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |(raw_d & ~mask);
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = |masked_stat;
      end
   endgenerate

endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
   import uirq_pkg::*;
#(
   parameter int  DEPTH   = 64,
   parameter bit  REG_IRQ = 1'b0,
   localparam int LVL_W   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_we,
   input  logic [2:0]       trig_rx_sel,
   input  logic [2:0]       trig_tx_sel,
   input  logic             mask_we,
   input  logic [11:0]      mask_wdata,
   input  logic             ctl_we,
   input  logic             ctl_rts_hw,
   input  logic             ctl_ign_err,
   input  logic             clr_we,
   input  logic [11:0]      clr_wdata,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] tx_level,
   input  logic             ev_overrun,
   input  logic             ev_break,
   input  logic             ev_parity,
   input  logic             ev_framing,
   input  logic             ev_rx_timeout,
   input  logic [3:0]       modem_chg,
   input  logic             err_data_pending,
   output logic [11:0]      raw_stat,
   output logic [11:0]      masked_stat,
   output logic             irq,
   output logic             rts_active
);

   generate
      if (DEPTH < 8 || (DEPTH % 8) != 0) begin : g_bad_depth
         $error("uirq_ctrl: DEPTH must be a positive multiple of 8");
      end
   endgenerate

   cfg_t             cfg;
   logic [NSTAT-1:0] mask;
   logic             rx_hit;
   logic             tx_hit;
   logic             rx_req;
   logic             rts_hw_q;
   logic [NSTAT-1:0] set_vec;

   uirq_cfg_regs #(.NST(NSTAT)) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_we     (trig_we),
      .trig_rx_sel (trig_rx_sel),
      .trig_tx_sel (trig_tx_sel),
      .ctl_we      (ctl_we),
      .ctl_rts_hw  (ctl_rts_hw),
      .ctl_ign_err (ctl_ign_err),
      .mask_we     (mask_we),
      .mask_wdata  (mask_wdata),
      .cfg         (cfg),
      .mask        (mask)
   );

   uirq_level_cmp #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx_cmp (
      .code  (cfg.rx_sel),
      .level (rx_level),
      .hit   (rx_hit)
   );

   uirq_level_cmp #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx_cmp (
      .code  (cfg.tx_sel),
      .level (tx_level),
      .hit   (tx_hit)
   );

   always_comb begin
      rx_req                 = rx_hit & (cfg.ign_err | ~err_data_pending);
      set_vec                = '0;
      set_vec[ST_ERRDATA]    = err_data_pending;
      set_vec[ST_OVERRUN]    = ev_overrun;
      set_vec[ST_BREAK]      = ev_break;
      set_vec[ST_PARITY]     = ev_parity;
      set_vec[ST_FRAMING]    = ev_framing;
      set_vec[ST_RXTMO]      = ev_rx_timeout;
      set_vec[ST_TXLVL]      = tx_hit;
      set_vec[ST_RXLVL]      = rx_req;
      set_vec[ST_DSR]        = modem_chg[3];
      set_vec[ST_DCD]        = modem_chg[2];
      set_vec[ST_CTS]        = modem_chg[1];
      set_vec[ST_RI]         = modem_chg[0];
   end

   uirq_status_bank #(
      .NST     (NSTAT),
      .RAW_RST (RAW_RESET),
      .REG_IRQ (REG_IRQ)
   ) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_vec     (set_vec),
      .clr_we      (clr_we),
      .clr_wdata   (clr_wdata),
      .mask        (mask),
      .raw_stat    (raw_stat),
      .masked_stat (masked_stat),
      .irq         (irq)
   );

   assign rts_hw_q   = cfg.rts_hw;
   // Request more data only while the receive queue sits below its trigger.
   assign rts_active = rts_hw_q & ~rx_hit;

endmodule

// File: rtl/uirq_ctrl_chk.sv
module uirq_ctrl_chk #(
   parameter int  DEPTH = 64,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_we,
   input logic [11:0]      clr_wdata,
   input logic             ctl_we,
   input logic             ctl_rts_hw,
   input logic             ev_overrun,
   input logic             ev_break,
   input logic             err_data_pending,
   input logic [LVL_W-1:0] rx_level,
   input logic [11:0]      raw_stat,
   input logic [11:0]      masked_stat,
   input logic             irq,
   input logic             rts_active,
   input logic             rts_hw_q
);

   p_ovr_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_overrun |=> raw_stat[10]);

   p_brk_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      raw_stat[9] && !(clr_we && clr_wdata[9]) |=> raw_stat[9]);

   p_brk_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_break |=> raw_stat[9]);

   p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we && clr_wdata[10] && !ev_overrun |=> !raw_stat[10]);

   p_masked_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (masked_stat & ~raw_stat) == 12'h000);

   p_irq_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (masked_stat != 12'h000));

   p_rts_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we && !ctl_rts_hw |=> !rts_active);

   p_rts_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rts_hw_q && (rx_level == '0) |-> rts_active);

   p_errdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_data_pending |=> raw_stat[11]);

endmodule

bind uirq_ctrl uirq_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .clr_we           (clr_we),
   .clr_wdata        (clr_wdata),
   .ctl_we           (ctl_we),
   .ctl_rts_hw       (ctl_rts_hw),
   .ev_overrun       (ev_overrun),
   .ev_break         (ev_break),
   .err_data_pending (err_data_pending),
   .rx_level         (rx_level),
   .raw_stat         (raw_stat),
   .masked_stat      (masked_stat),
   .irq              (irq),
   .rts_active       (rts_active),
   .rts_hw_q         (rts_hw_q)
);

// File: tb/uirq_ctrl_bench.sv
`timescale 1ns/1ps
module uirq_ctrl_bench;

   localparam int DEPTH = 64;
   localparam int LW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig_we = 0, mask_we = 0, ctl_we = 0, clr_we = 0;
   logic [2:0]    trig_rx_sel = 0, trig_tx_sel = 0;
   logic [11:0]   mask_wdata = 0, clr_wdata = 0;
   logic          ctl_rts_hw = 0, ctl_ign_err = 0;
   logic [LW-1:0] rx_level = 0, tx_level = 0;
   logic          ev_overrun = 0, ev_break = 0, ev_parity = 0, ev_framing = 0, ev_rx_timeout = 0;
   logic [3:0]    modem_chg = 0;
   logic          err_data_pending = 0;
   logic [11:0]   raw_stat, masked_stat;
   logic          irq, rts_active;

   always #5 clk = ~clk;

   uirq_ctrl #(.DEPTH(DEPTH)) u_uirq_ctrl (.*);

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    running = 0;
   bit    done = 0;

   // Behavioural reference state.
   int m_raw, m_mask, m_rxsel, m_txsel, m_hw, m_ign;

   function automatic bit rx_met(int code, int lvl);
      int e[5] = '{1, 2, 4, 6, 7};
      if (code <= 4) return (lvl * 8) >= (DEPTH * e[code]);
      if (code == 5) return lvl >= 1;
      if (code == 6) return lvl >= 2;
      return 0;
   endfunction

   function automatic bit tx_met(int code, int lvl);
      int e[5] = '{1, 2, 4, 6, 7};
      if (code <= 4) return (lvl * 8) < (DEPTH * e[code]);
      return 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_raw <= 'h020; m_mask <= 'hFFF; m_rxsel <= 2; m_txsel <= 2; m_hw <= 0; m_ign <= 0;
      end else begin
         int s;
         int c;
         s = 0;
         if (err_data_pending) s |= 1 << 11;
         if (ev_overrun)       s |= 1 << 10;
         if (ev_break)         s |= 1 << 9;
         if (ev_parity)        s |= 1 << 8;
         if (ev_framing)       s |= 1 << 7;
         if (ev_rx_timeout)    s |= 1 << 6;
         if (tx_met(m_txsel, int'(tx_level))) s |= 1 << 5;
         if (rx_met(m_rxsel, int'(rx_level)) && (m_ign != 0 || !err_data_pending)) s |= 1 << 4;
         s |= int'(modem_chg);
         c = clr_we ? int'(clr_wdata) : 0;
         m_raw <= ((m_raw & ~c) | s) & 'hFFF;
         if (mask_we) m_mask <= int'(mask_wdata);
         if (trig_we) begin m_rxsel <= int'(trig_rx_sel); m_txsel <= int'(trig_tx_sel); end
         if (ctl_we) begin m_hw <= int'(ctl_rts_hw); m_ign <= int'(ctl_ign_err); end
      end
   end

   task automatic chk(string req, int got, int exp, string what);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", req, what, got, exp, $time);
      end
   endtask

   // Per-clock comparison against the reference, away from the edge.
   always @(posedge clk) begin
      #2;
      if (rst_n && running) begin
         int em;
         int er;
         em = m_raw & ~m_mask & 'hFFF;
         er = (m_hw != 0 && !rx_met(m_rxsel, int'(rx_level))) ? 1 : 0;
         chk(cur_req, int'(raw_stat), m_raw, "raw_stat");
         chk("R7", int'(masked_stat), em, "masked_stat");
         chk("R7", int'(irq), (em != 0) ? 1 : 0, "irq");
         chk("R8", int'(rts_active), er, "rts_active");
      end
   end

   task automatic cyc();
      @(negedge clk);
      trig_we = 0; mask_we = 0; ctl_we = 0; clr_we = 0;
      ev_overrun = 0; ev_break = 0; ev_parity = 0; ev_framing = 0; ev_rx_timeout = 0;
      modem_chg = 0;
   endtask

   logic [15:0] lf = 16'hACE1;
   task automatic lfsr_step();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
   endtask

   initial begin : watchdog
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", int'(raw_stat), 'h020, "raw_stat in reset");
      chk("R1", int'(irq), 0, "irq in reset");
      rst_n = 1;
      @(negedge clk);
      chk("R1", int'(raw_stat), 'h020, "raw_stat after reset");
      chk("R1", int'(masked_stat), 0, "masked_stat after reset");
      chk("R1", int'(rts_active), 0, "rts_active after reset");
      running = 1;

      // R10: unmask and enable hardware RTS; status in the writing edge uses old mask.
      cur_req = "R10";
      mask_wdata = 12'h000; mask_we = 1; ctl_rts_hw = 1; ctl_we = 1;
      cyc();
      chk("R10", int'(masked_stat), 'h020, "mask applied after its edge");
      chk("R8", int'(rts_active), 1, "rts with empty rx queue");

      // R2/R3: receive trigger sweep, clearing every cycle.
      for (int c = 0; c < 8; c++) begin
         cur_req = (c <= 4) ? "R2" : "R3";
         trig_rx_sel = 3'(c); trig_tx_sel = 3'd2; trig_we = 1; cyc();
         for (int l = 0; l <= DEPTH; l++) begin
            rx_level = LW'(l); clr_we = 1; clr_wdata = 12'hFFF; cyc();
         end
         rx_level = 0;
      end
      // R2: directed boundary on half trigger
      trig_rx_sel = 3'd2; trig_we = 1; cyc();
      rx_level = LW'(31); clr_we = 1; clr_wdata = 12'hFFF; cyc();
      chk("R2", int'(raw_stat[4]), 0, "rx bit at 31 of 64, half code");
      rx_level = LW'(32); clr_we = 1; clr_wdata = 12'hFFF; cyc();
      chk("R2", int'(raw_stat[4]), 1, "rx bit at 32 of 64, half code");
      chk("R8", int'(rts_active), 0, "rts at trigger level");
      trig_rx_sel = 3'd7; trig_we = 1; cyc();
      rx_level = LW'(DEPTH); clr_we = 1; clr_wdata = 12'hFFF; cyc();
      chk("R3", int'(raw_stat[4]), 0, "reserved rx code with full queue");
      chk("R8", int'(rts_active), 1, "rts with reserved rx code");
      rx_level = 0;

      // R4: transmit trigger sweep.
      for (int c = 0; c < 8; c++) begin
         cur_req = "R4";
         trig_rx_sel = 3'd2; trig_tx_sel = 3'(c); trig_we = 1; cyc();
         for (int l = DEPTH; l >= 0; l--) begin
            tx_level = LW'(l); clr_we = 1; clr_wdata = 12'hFFF; cyc();
         end
      end
      trig_tx_sel = 3'd0; trig_we = 1; cyc();
      tx_level = LW'(8); clr_we = 1; clr_wdata = 12'hFFF; cyc();
      chk("R4", int'(raw_stat[5]), 0, "tx bit at 8 with eighth code");
      tx_level = LW'(7); clr_we = 1; clr_wdata = 12'hFFF; cyc();
      chk("R4", int'(raw_stat[5]), 1, "tx bit at 7 with eighth code");
      trig_tx_sel = 3'd5; trig_we = 1; cyc();
      tx_level = 0; clr_we = 1; clr_wdata = 12'hFFF; cyc();
      chk("R4", int'(raw_stat[5]), 0, "reserved tx code with empty queue");

      // R5/R6: directed sticky and clear behaviour on the overrun bit (10).
      cur_req = "R5";
      clr_we = 1; clr_wdata = 12'hFFF; cyc();
      ev_overrun = 1; cyc();
      chk("R5", int'(raw_stat[10]), 1, "overrun sets bit 10");
      cyc(); cyc();
      chk("R5", int'(raw_stat[10]), 1, "overrun bit holds");
      cur_req = "R6";
      clr_we = 1; clr_wdata = 12'hBFF; cyc();
      chk("R6", int'(raw_stat[10]), 1, "clear with 0 in bit 10 leaves it");
      clr_we = 1; clr_wdata = 12'h400; cyc();
      chk("R6", int'(raw_stat[10]), 0, "clear with 1 in bit 10");
      ev_overrun = 1; clr_we = 1; clr_wdata = 12'h400; cyc();
      chk("R6", int'(raw_stat[10]), 1, "set wins over same-cycle clear");
      modem_chg = 4'b1010; ev_parity = 1; cyc();
      chk("R5", int'(raw_stat & 12'h10F), 'h10A, "parity bit 8 and modem DSR/CTS bits");

      // R7: mask behaviour.
      cur_req = "R7";
      mask_wdata = 12'hFFF; mask_we = 1; cyc();
      chk("R7", int'(irq), 0, "irq fully masked");
      mask_wdata = 12'hBFF; mask_we = 1; cyc();
      chk("R7", int'(masked_stat), 'h400, "only overrun unmasked");
      chk("R7", int'(irq), 1, "irq with unmasked overrun");

      // R5/R6/R7 pseudo-random mix.
      cur_req = "R5";
      trig_rx_sel = 3'd1; trig_tx_sel = 3'd3; trig_we = 1; cyc();
      for (int i = 0; i < 600; i++) begin
         lfsr_step();
         ev_overrun = lf[0] & lf[5]; ev_break = lf[1] & lf[6]; ev_parity = lf[2] & lf[7];
         ev_framing = lf[3] & lf[8]; ev_rx_timeout = lf[4] & lf[9];
         modem_chg = lf[13:10] & lf[3:0];
         clr_we = lf[14]; clr_wdata = {lf[3:0], lf[15:8]};
         rx_level = LW'(lf[6:0] % (DEPTH + 1)); tx_level = LW'(lf[12:6] % (DEPTH + 1));
         if (lf[15] & lf[2] & lf[9]) begin mask_we = 1; mask_wdata = lf[11:0]; end
         cyc();
      end

      // R9: error data gating.
      cur_req = "R9";
      mask_wdata = 12'h000; mask_we = 1; ctl_rts_hw = 1; ctl_ign_err = 0; ctl_we = 1;
      trig_rx_sel = 3'd2; trig_tx_sel = 3'd2; trig_we = 1; cyc();
      rx_level = LW'(40); err_data_pending = 1; clr_we = 1; clr_wdata = 12'hFFF; cyc();
      chk("R9", int'(raw_stat[4]), 0, "rx bit blocked by error data");
      chk("R9", int'(raw_stat[11]), 1, "error data bit 11");
      ctl_rts_hw = 1; ctl_ign_err = 1; ctl_we = 1; clr_we = 1; clr_wdata = 12'hFFF; cyc();
      chk("R10", int'(raw_stat[4]), 0, "ignore bit not used in its own edge");
      clr_we = 1; clr_wdata = 12'hFFF; cyc();
      chk("R9", int'(raw_stat[4]), 1, "rx bit with ignore set");
      err_data_pending = 0; clr_we = 1; clr_wdata = 12'h800; cyc();
      chk("R9", int'(raw_stat[11]), 0, "bit 11 cleared after pending drops");

      // R8: disable hardware RTS.
      cur_req = "R8";
      rx_level = 0; ctl_rts_hw = 0; ctl_we = 1; cyc();
      chk("R8", int'(rts_active), 0, "rts disabled");
      cyc(); cyc();

      done = 1;
      running = 0;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule